// File: doc/BRIEF.md
# Static Branch Direction Predictor with Pipeline Flush

This block sits next to a short in-order pipeline. For every branch that leaves decode it gives a predicted direction. The prediction comes only from the branch class and from whether the target lies behind or ahead of the branch. It also states whether a jump may be folded, meaning it issues alongside the instruction before it and takes no cycle of its own.

When the execute side later reports the real outcome and that outcome disagrees with the prediction, the block does three things. It raises a one-cycle flush that cancels the younger instructions. It supplies the correct fetch address. It holds the pipeline for a fixed penalty.

The block also reports a cycle cost for each retired instruction frame. A misprediction penalty is charged to the frame that follows the branch. A folded jump has no frame of its own, so its resolution is flagged on the next frame.

Top module: `static_branch_predictor`

## Requirements
- R1: For a bit-conditional branch (kind code 0), `pred_taken` is 1 exactly when the target is backward. Backward means `dec_tgt <= dec_pc` under an unsigned compare.
- R2: For relative (1), absolute (2) and inter-segment (3) kinds, `pred_taken` is 1 when `dec_uncond` is 1 or the target is backward, and 0 otherwise.
- R3: `fold_ok` is 1 only for a valid branch of kind 1, 2 or 3. It is 0 when the most recent accepted decoded instruction was a branch.
- R4: One cycle after a resolution that disagrees with the stored prediction, `flush` is high for exactly one cycle. `redirect_pc` is then the stored target if the branch was taken, or the branch PC plus 2 if it was not.
- R5: `stall` is high for exactly 5 cycles, starting in the same cycle as `flush`. Decode inputs presented while `stall` is high are ignored, so a branch decoded then can never cause a flush.
- R6: A resolution that agrees with the prediction gives no flush and no stall.
- R7: A frame report (`rpt_valid`, one cycle after `ret_valid`) gives cost 1 normally. It gives cost 6 for the first frame after a misprediction, and the frames after that return to cost 1.
- R8: When a folded branch resolves, the next frame report has `rpt_zc` set. If that folded branch mispredicted, the same report also carries the penalty.
- R9: A resolution with no pending branch has no effect: no flush and no stall.
- R10: After reset, `flush`, `stall` and `rpt_valid` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dec_valid | input | 1 | An instruction leaves decode |
| dec_br | input | 1 | That instruction is a branch |
| dec_kind | input | 2 | Branch class: 0 bit-cond, 1 relative, 2 absolute, 3 inter-segment |
| dec_uncond | input | 1 | Branch has no condition |
| dec_pc | input | 24 | Address of the decoded instruction |
| dec_tgt | input | 24 | Branch target address |
| res_valid | input | 1 | Execute reports the outcome of the pending branch |
| res_taken | input | 1 | Actual direction |
| ret_valid | input | 1 | An instruction frame retires |
| pred_taken | output | 1 | Predicted direction for the decoded branch |
| fold_ok | output | 1 | Decoded jump may issue with zero cycles |
| flush | output | 1 | Cancel younger instructions |
| redirect_pc | output | 24 | Correct fetch address, valid with flush |
| stall | output | 1 | Pipeline hold during penalty |
| rpt_valid | output | 1 | Frame cost report valid |
| rpt_cycles | output | 3 | Cycles charged to the frame |
| rpt_zc | output | 1 | A zero-cycle branch resolved before this frame |

## Verification
A pending-branch register holding the wrong direction shows up at the ports one cycle after resolution. It either produces a flush where none was due or misses one that was due, and a wrong stored target shows in `redirect_pc` on that same cycle. A wrong penalty counter shows as a stall window of the wrong length, visible within six cycles. The frame-cost state only shows up at the next retired frame, as a wrong cost or a missing zero-cycle flag. The bench therefore always retires a frame after each resolution.

// File: rtl/bp_pkg.sv
package bp_pkg;
  typedef enum logic [1:0] {
    BK_BITCOND = 2'd0,
    BK_REL     = 2'd1,
    BK_ABS     = 2'd2,
    BK_SEG     = 2'd3
  } br_kind_e;
endpackage

// File: rtl/bp_dir_rule.sv
module bp_dir_rule
  import bp_pkg::*;
#(
  parameter int AW = 24
) (
  input  logic [1:0]    kind,
  input  logic          uncond,
  input  logic [AW-1:0] pc,
  input  logic [AW-1:0] tgt,
  output logic          pred
);
  logic backward;

  always_comb begin
    backward = (tgt <= pc);
    if (br_kind_e'(kind) == BK_BITCOND) pred = backward;
    else                                pred = uncond | backward;
  end
endmodule

// File: rtl/bp_fold_gate.sv
module bp_fold_gate
  import bp_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       accept,
  input  logic       dec_valid,
  input  logic       dec_br,
  input  logic [1:0] kind,
  output logic       fold_ok
);
  logic last_br_q, last_br_d;

  always_comb begin
    last_br_d = last_br_q;
    if (accept && dec_valid) last_br_d = dec_br;
    fold_ok = dec_valid && dec_br && !last_br_q &&
              (br_kind_e'(kind) != BK_BITCOND);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) last_br_q <= 1'b0;
    else        last_br_q <= last_br_d;
  end

  // R3
  fold_after_branch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_valid && dec_br && accept) |=> !fold_ok);
endmodule

// File: rtl/bp_resolve.sv
module bp_resolve #(
  parameter int AW        = 24,
  parameter int PENALTY   = 5,
  parameter int STEP      = 2,
  parameter int CW        = $clog2(PENALTY + 2)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cap,
  input  logic          pred,
  input  logic          fold,
  input  logic [AW-1:0] pc,
  input  logic [AW-1:0] tgt,
  input  logic          res_valid,
  input  logic          res_taken,
  output logic          mispred,
  output logic          zc_evt,
  output logic          flush,
  output logic [AW-1:0] redirect_pc,
  output logic          stall
);
  logic          pend_v_q, pend_v_d;
  logic          pend_pred_q, pend_pred_d;
  logic          pend_fold_q, pend_fold_d;
  logic [AW-1:0] pend_tgt_q, pend_tgt_d;
  logic [AW-1:0] pend_fall_q, pend_fall_d;
  logic          flush_q, flush_d;
  logic [AW-1:0] redir_q, redir_d;
  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    mispred     = res_valid && pend_v_q && (res_taken != pend_pred_q);
    zc_evt      = res_valid && pend_v_q && pend_fold_q;
    pend_v_d    = pend_v_q;
    pend_pred_d = pend_pred_q;
    pend_fold_d = pend_fold_q;
    pend_tgt_d  = pend_tgt_q;
    pend_fall_d = pend_fall_q;
    if (mispred)        pend_v_d = 1'b0;
    else if (cap) begin
      pend_v_d    = 1'b1;
      pend_pred_d = pred;
      pend_fold_d = fold;
      pend_tgt_d  = tgt;
      pend_fall_d = pc + AW'(STEP);
    end else if (res_valid) pend_v_d = 1'b0;
    flush_d = mispred;
    redir_d = redir_q;
    if (mispred) redir_d = res_taken ? pend_tgt_q : pend_fall_q;
    if (mispred)              cnt_d = CW'(PENALTY);
    else if (cnt_q != '0)     cnt_d = cnt_q - 1'b1;
    else                      cnt_d = cnt_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_v_q    <= 1'b0;
      pend_pred_q <= 1'b0;
      pend_fold_q <= 1'b0;
      pend_tgt_q  <= '0;
      pend_fall_q <= '0;
      flush_q     <= 1'b0;
      redir_q     <= '0;
      cnt_q       <= '0;
    end else begin
      pend_v_q    <= pend_v_d;
      pend_pred_q <= pend_pred_d;
      pend_fold_q <= pend_fold_d;
      pend_tgt_q  <= pend_tgt_d;
      pend_fall_q <= pend_fall_d;
      flush_q     <= flush_d;
      redir_q     <= redir_d;
      cnt_q       <= cnt_d;
    end
  end

  assign flush       = flush_q;
  assign redirect_pc = redir_q;
  assign stall       = (cnt_q != '0);

  // R4
  flush_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> !flush);
  // R5
  flush_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush |-> stall);
  // R5
  stall_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CW'(PENALTY));
  // R9
  idle_resolve_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !pend_v_q) |=> !flush);
endmodule

// File: rtl/bp_frame_cost.sv
module bp_frame_cost #(
  parameter int PENALTY = 5,
  parameter int CW      = $clog2(PENALTY + 2)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          mispred,
  input  logic          zc_evt,
  input  logic          ret_valid,
  output logic          rpt_valid,
  output logic [CW-1:0] rpt_cycles,
  output logic          rpt_zc
);
  logic          owed_q, owed_d;
  logic          zcp_q, zcp_d;
  logic          rv_q;
  logic [CW-1:0] cyc_q, cyc_d;
  logic          zc_q, zc_d;

  always_comb begin
    owed_d = owed_q;
    zcp_d  = zcp_q;
    cyc_d  = cyc_q;
    zc_d   = zc_q;
    if (ret_valid) begin
      cyc_d  = owed_q ? CW'(PENALTY + 1) : CW'(1);
      zc_d   = zcp_q;
      owed_d = 1'b0;
      zcp_d  = 1'b0;
    end
    if (mispred) owed_d = 1'b1;
    if (zc_evt)  zcp_d  = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      owed_q <= 1'b0;
      zcp_q  <= 1'b0;
      rv_q   <= 1'b0;
      cyc_q  <= '0;
      zc_q   <= 1'b0;
    end else begin
      owed_q <= owed_d;
      zcp_q  <= zcp_d;
      rv_q   <= ret_valid;
      cyc_q  <= cyc_d;
      zc_q   <= zc_d;
    end
  end

  assign rpt_valid  = rv_q;
  assign rpt_cycles = cyc_q;
  assign rpt_zc     = zc_q;

  // R7
  rpt_cost_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rpt_valid |-> (rpt_cycles == CW'(1) || rpt_cycles == CW'(PENALTY + 1)));
  // R7
  penalty_consumed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ret_valid && !mispred) |=> !owed_q);
endmodule

// File: rtl/static_branch_predictor.sv
module static_branch_predictor #(
  parameter int AW      = 24,
  parameter int PENALTY = 5,
  parameter int STEP    = 2,
  parameter int CW      = $clog2(PENALTY + 2)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          dec_valid,
  input  logic          dec_br,
  input  logic [1:0]    dec_kind,
  input  logic          dec_uncond,
  input  logic [AW-1:0] dec_pc,
  input  logic [AW-1:0] dec_tgt,
  input  logic          res_valid,
  input  logic          res_taken,
  input  logic          ret_valid,
  output logic          pred_taken,
  output logic          fold_ok,
  output logic          flush,
  output logic [AW-1:0] redirect_pc,
  output logic          stall,
  output logic          rpt_valid,
  output logic [CW-1:0] rpt_cycles,
  output logic          rpt_zc
);
  logic raw_pred, accept, cap, mispred, zc_evt;

  assign accept     = !stall;
  assign cap        = dec_valid && dec_br && accept;
  assign pred_taken = dec_valid && dec_br && raw_pred;

  bp_dir_rule #(.AW(AW)) u_rule (
    .kind(dec_kind), .uncond(dec_uncond), .pc(dec_pc), .tgt(dec_tgt),
    .pred(raw_pred));

  bp_fold_gate u_fold (
    .clk(clk), .rst_n(rst_n), .accept(accept), .dec_valid(dec_valid),
    .dec_br(dec_br), .kind(dec_kind), .fold_ok(fold_ok));

  bp_resolve #(.AW(AW), .PENALTY(PENALTY), .STEP(STEP), .CW(CW)) u_res (
    .clk(clk), .rst_n(rst_n), .cap(cap), .pred(raw_pred), .fold(fold_ok),
    .pc(dec_pc), .tgt(dec_tgt), .res_valid(res_valid), .res_taken(res_taken),
    .mispred(mispred), .zc_evt(zc_evt), .flush(flush),
    .redirect_pc(redirect_pc), .stall(stall));

  bp_frame_cost #(.PENALTY(PENALTY), .CW(CW)) u_cost (
    .clk(clk), .rst_n(rst_n), .mispred(mispred), .zc_evt(zc_evt),
    .ret_valid(ret_valid), .rpt_valid(rpt_valid), .rpt_cycles(rpt_cycles),
    .rpt_zc(rpt_zc));

  // R3
  fold_needs_branch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fold_ok |-> (dec_valid && dec_br));
endmodule

// File: tb/static_branch_predictor_tb.sv
module static_branch_predictor_tb;
  localparam int AW = 24;
  logic clk = 1'b0;
  logic rst_n;
  logic dec_valid, dec_br, dec_uncond, res_valid, res_taken, ret_valid;
  logic [1:0] dec_kind;
  logic [AW-1:0] dec_pc, dec_tgt;
  logic pred_taken, fold_ok, flush, stall, rpt_valid, rpt_zc;
  logic [AW-1:0] redirect_pc;
  logic [2:0] rpt_cycles;

  int n_chk = 0, n_fail = 0;
  logic [AW-1:0] flush_q[$];
  logic [3:0]    frame_q[$];
  logic b_live, b_pred, b_fold, owed, zcp;
  logic [AW-1:0] b_tgt, b_fall;

  always #10 clk = ~clk;

  static_branch_predictor u_dut (
    .clk(clk), .rst_n(rst_n), .dec_valid(dec_valid), .dec_br(dec_br),
    .dec_kind(dec_kind), .dec_uncond(dec_uncond), .dec_pc(dec_pc),
    .dec_tgt(dec_tgt), .res_valid(res_valid), .res_taken(res_taken),
    .ret_valid(ret_valid), .pred_taken(pred_taken), .fold_ok(fold_ok),
    .flush(flush), .redirect_pc(redirect_pc), .stall(stall),
    .rpt_valid(rpt_valid), .rpt_cycles(rpt_cycles), .rpt_zc(rpt_zc));

  task automatic check(input logic ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic clear_in();
    dec_valid = 0; dec_br = 0; dec_kind = 0; dec_uncond = 0;
    dec_pc = '0; dec_tgt = '0; res_valid = 0; res_taken = 0; ret_valid = 0;
  endtask

  task automatic plain_op();
    @(negedge clk); dec_valid = 1; dec_br = 0; dec_pc = 24'h10;
    @(posedge clk); #1 clear_in();
  endtask

  task automatic issue_br(input logic [1:0] k, input logic unc, input logic [AW-1:0] pc,
                          input logic [AW-1:0] tgt, input logic ep, input logic ef,
                          input logic acc, input string req);
    @(negedge clk);
    dec_valid = 1; dec_br = 1; dec_kind = k; dec_uncond = unc; dec_pc = pc; dec_tgt = tgt;
    #1;
    check(pred_taken == ep, req, pred_taken, ep);
    check(fold_ok == ef, req, fold_ok, ef);
    if (acc) begin
      b_live = 1; b_pred = ep; b_fold = ef; b_tgt = tgt; b_fall = pc + 24'd2;
    end
    @(posedge clk); #1 clear_in();
  endtask

  task automatic resolve(input logic tk, input logic hold, input string req);
    logic mis;
    @(negedge clk);
    res_valid = 1; res_taken = tk;
    mis = b_live && (tk != b_pred);
    if (mis) begin
      flush_q.push_back(tk ? b_tgt : b_fall);
      owed = 1;
    end
    if (b_live && b_fold) zcp = 1;
    b_live = 0;
    @(posedge clk); #1 clear_in();
    if (hold) begin
      if (mis) begin
        for (int i = 0; i < 5; i++) begin
          @(negedge clk); check(stall == 1'b1, "R5", stall, 1);
        end
      end
      @(negedge clk); check(stall == 1'b0, mis ? "R5" : req, stall, 0);
    end
  endtask

  task automatic frame(input string req);
    @(negedge clk); ret_valid = 1;
    frame_q.push_back({zcp, owed ? 3'd6 : 3'd1});
    owed = 0; zcp = 0;
    @(posedge clk); #1 clear_in();
    @(negedge clk);
  endtask

  // monitor: pops expected items as results appear
  always @(negedge clk) begin
    if (rst_n) begin
      if (flush) begin
        if (flush_q.size() == 0) check(1'b0, "R4/R6/R9 unexpected flush", 1, 0);
        else begin
          logic [AW-1:0] e;
          e = flush_q.pop_front();
          check(redirect_pc == e, "R4 redirect", redirect_pc, e);
        end
      end
      if (rpt_valid) begin
        if (frame_q.size() == 0) check(1'b0, "R7 unexpected report", 1, 0);
        else begin
          logic [3:0] e;
          e = frame_q.pop_front();
          check(rpt_cycles == e[2:0], "R7 cost", rpt_cycles, e[2:0]);
          check(rpt_zc == e[3], "R8 zero-cycle flag", rpt_zc, e[3]);
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    check(1'b0, "watchdog", 0, 1);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    b_live = 0; b_pred = 0; b_fold = 0; owed = 0; zcp = 0; b_tgt = '0; b_fall = '0;
    clear_in();
    rst_n = 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(negedge clk);
    // R10
    check(flush == 0, "R10", flush, 0);
    check(stall == 0, "R10", stall, 0);
    check(rpt_valid == 0, "R10", rpt_valid, 0);

    // R1 backward bit-cond, correct -> R6
    plain_op();
    issue_br(2'd0, 0, 24'h100, 24'h0F0, 1, 0, 1, "R1");
    resolve(1, 1, "R6");
    frame("R7");
    // R1 forward bit-cond, mispredicted -> R4 R5 R7
    plain_op();
    issue_br(2'd0, 0, 24'h200, 24'h240, 0, 0, 1, "R1");
    resolve(1, 1, "R4");
    frame("R7");
    frame("R7");
    // R1 unsigned compare: huge target is forward
    plain_op();
    issue_br(2'd0, 0, 24'h000010, 24'hFFFFF0, 0, 0, 1, "R1");
    resolve(0, 1, "R6");
    frame("R7");
    // R2 R8 unconditional forward relative, folded, correct
    plain_op();
    issue_br(2'd1, 1, 24'h300, 24'h380, 1, 1, 1, "R2");
    resolve(1, 1, "R6");
    frame("R8");
    // R8 conditional forward relative folded, mispredicted
    plain_op();
    issue_br(2'd1, 0, 24'h400, 24'h420, 0, 1, 1, "R2");
    resolve(1, 1, "R8");
    frame("R8");
    // R3 previous accepted decode was a branch: no fold; equal target is backward
    issue_br(2'd1, 0, 24'h500, 24'h500, 1, 0, 1, "R3");
    resolve(0, 1, "R4");
    frame("R7");
    // R2 absolute backward then inter-segment right after it
    plain_op();
    issue_br(2'd2, 0, 24'h600, 24'h010, 1, 1, 1, "R2");
    issue_br(2'd3, 1, 24'h700, 24'h900, 1, 0, 1, "R3");
    resolve(1, 1, "R6");
    frame("R7");
    // R9 resolution with nothing pending
    resolve(0, 1, "R9");
    frame("R9");
    // R5 decode during stall is ignored
    plain_op();
    issue_br(2'd0, 0, 24'h800, 24'h900, 0, 0, 1, "R1");
    resolve(1, 0, "R5");
    issue_br(2'd0, 0, 24'hA00, 24'h9F0, 1, 0, 0, "R5");
    repeat (6) @(posedge clk);
    resolve(0, 1, "R5");
    frame("R7");
    repeat (3) @(negedge clk);
    check(flush_q.size() == 0, "R4 missing flush", flush_q.size(), 0);
    check(frame_q.size() == 0, "R7 missing report", frame_q.size(), 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule